// File: doc/BRIEF.md
# Shared-Address Divisor-High and Frame-Control Register Pair

This block holds two configuration registers of a serial port behind a single bus address. One is the upper part of a baud-rate divisor. The other is the frame-format control register, which holds fields such as stop-bit selection and character size. The two registers are never told apart by address. On a write, the most significant bit of the write data selects the target. On a read, timing selects the target: a read that stands alone returns the divisor-high value. A read issued in the clock cycle directly after another read of the same address returns the frame-control value.

The bus is a plain synchronous peripheral bus with an address, a write strobe, a read strobe, write data and read data. Read data is combinational in the cycle of the read strobe. Writes take effect at the clock edge that samples the strobe. Both register values are also driven out in parallel for the baud generator and the serial engine. Those consumers are not part of this block. The bus has no back-pressure: every strobe completes in its own cycle.

Top module: `shreg_pair`

## Requirements
- R1: After reset the divisor-high register is 0, the frame-control register is 0x86, and the read-sequence state is cleared, so the first read after reset returns the divisor-high value.
- R2: A write strobe to the shared address with write-data bit 7 equal to 0 loads write-data bits 3:0 into the divisor-high register at that clock edge and leaves the frame-control register unchanged. For example, 0x02 gives a divisor-high value of 2.
- R3: A write strobe to the shared address with write-data bit 7 equal to 1 loads write-data bits 6:0 into the frame-control register and leaves the divisor-high register unchanged. Writing 0x8C (bit 7, stop-select bit 3 and character-size bit 2) stores exactly 0x8C.
- R4: A write strobe to any other address changes neither register.
- R5: A read strobe to the shared address that is not directly preceded by one returns the divisor-high value in bits 3:0, with bits 7:4 equal to 0.
- R6: A read strobe to the shared address in the cycle straight after another read strobe to it returns the frame-control value, and bit 7 of that read data is always 1.
- R7: Any cycle without a read strobe to the shared address breaks the sequence. This includes an idle cycle, a write, and a read of another address. The next read of the shared address returns the divisor-high value again.
- R8: Three reads of the shared address in consecutive cycles return divisor-high, then frame-control, then frame-control.
- R9: Read data is 0 in every cycle without a read strobe to the shared address.
- R10: Write-data bits 6:4 of a divisor-high write are ignored. Writing 0x7F leaves the divisor-high register at 0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (6) | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W (8) | Write data; bit 7 selects the target register |
| bus_rdata | output | DATA_W (8) | Read data, valid in the cycle of the read strobe |
| div_hi_o | output | DIV_HI_W (4) | Current divisor-high value |
| frame_o | output | DATA_W (8) | Current frame-control value, bit 7 always 1 |

## Verification
A wrong read-sequence flag shows up in the same cycle as the next shared-address read. That read returns the frame value where the divisor value was expected, or the reverse. Idle, write and foreign-address cycles are therefore placed between reads to expose a flag that is held too long or set by the wrong strobe. A misrouted or partial write shows up one cycle later on the parallel outputs. It also shows up on the next read of the affected register. So every write is followed by checks of both outputs and of a read pair.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  // Target of a bus write after address and select decode
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_DIV   = 2'd1,
    TGT_FRAME = 2'd2
  } wr_tgt_e;
endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
  import shreg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] SHARED_ADDR = 6'h20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              sel_bit,
  output wr_tgt_e           tgt,
  output logic              rd_hit
);
  logic hit;

  assign hit    = (addr == SHARED_ADDR);
  assign rd_hit = rd & hit;

  always_comb begin
    tgt = TGT_NONE;
    if (wr && hit) begin
      tgt = sel_bit ? TGT_FRAME : TGT_DIV;
    end
  end
endmodule

// File: rtl/shreg_seq.sv
module shreg_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_hit,
  output logic prev_rd
);
  // Set only by a shared-address read, cleared by every other cycle
  always_ff @(posedge clk) begin
    if (!rst_n) prev_rd <= 1'b0;
    else        prev_rd <= rd_hit;
  end
endmodule

// File: rtl/shreg_store.sv
module shreg_store
  import shreg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HI_W = 4,
  parameter logic [DATA_W-2:0] FRAME_RST = 7'h06
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wr_tgt_e             tgt,
  input  logic [DATA_W-2:0]   wdata_lo,
  output logic [DIV_HI_W-1:0] div_q,
  output logic [DATA_W-2:0]   frm_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (tgt == TGT_DIV) begin
      div_q <= wdata_lo[DIV_HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_q <= FRAME_RST;
    end else if (tgt == TGT_FRAME) begin
      frm_q <= wdata_lo;
    end
  end
endmodule

// File: rtl/shreg_rdmux.sv
module shreg_rdmux #(
  parameter int DATA_W   = 8,
  parameter int DIV_HI_W = 4
) (
  input  logic                rd_hit,
  input  logic                prev_rd,
  input  logic [DIV_HI_W-1:0] div_q,
  input  logic [DATA_W-2:0]   frm_q,
  output logic [DATA_W-1:0]   rdata
);
  localparam int PAD_W = DATA_W - DIV_HI_W;

  logic [DATA_W-1:0] div_view;
  logic [DATA_W-1:0] frm_view;

  generate
    if (PAD_W > 0) begin : g_pad
      assign div_view = {{PAD_W{1'b0}}, div_q};
    end else begin : g_nopad
      assign div_view = div_q[DATA_W-1:0];
    end
  endgenerate

  assign frm_view = {1'b1, frm_q};

  always_comb begin
    rdata = '0;
    if (rd_hit) rdata = prev_rd ? frm_view : div_view;
  end
endmodule

// File: rtl/shreg_pair.sv
module shreg_pair
  import shreg_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int DIV_HI_W = 4,
  parameter logic [ADDR_W-1:0] SHARED_ADDR = 6'h20,
  parameter logic [DATA_W-1:0] FRAME_RST   = 8'h86
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [DIV_HI_W-1:0] div_hi_o,
  output logic [DATA_W-1:0]   frame_o
);
  localparam int SEL_BIT = DATA_W - 1;

  wr_tgt_e             tgt;
  logic                rd_hit;
  logic                prev_rd;
  logic [DIV_HI_W-1:0] div_q;
  logic [DATA_W-2:0]   frm_q;

  shreg_decode #(.ADDR_W(ADDR_W), .SHARED_ADDR(SHARED_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .sel_bit(bus_wdata[SEL_BIT]), .tgt(tgt), .rd_hit(rd_hit)
  );

  shreg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .prev_rd(prev_rd)
  );

  shreg_store #(
    .DATA_W(DATA_W), .DIV_HI_W(DIV_HI_W), .FRAME_RST(FRAME_RST[DATA_W-2:0])
  ) u_store (
    .clk(clk), .rst_n(rst_n), .tgt(tgt),
    .wdata_lo(bus_wdata[DATA_W-2:0]), .div_q(div_q), .frm_q(frm_q)
  );

  shreg_rdmux #(.DATA_W(DATA_W), .DIV_HI_W(DIV_HI_W)) u_mux (
    .rd_hit(rd_hit), .prev_rd(prev_rd), .div_q(div_q), .frm_q(frm_q),
    .rdata(bus_rdata)
  );

  assign div_hi_o = div_q;
  assign frame_o  = {1'b1, frm_q};
endmodule

// File: rtl/shreg_pair_chk.sv
module shreg_pair_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int DIV_HI_W = 4,
  parameter logic [ADDR_W-1:0] SHARED_ADDR = 6'h20
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [DIV_HI_W-1:0] div_hi_o,
  input logic [DATA_W-1:0]   frame_o
);
  localparam int PAD_W = DATA_W - DIV_HI_W;

  logic rd_s, wr_div_s, wr_frm_s;
  assign rd_s     = bus_rd && (bus_addr == SHARED_ADDR);
  assign wr_div_s = bus_wr && (bus_addr == SHARED_ADDR) && !bus_wdata[DATA_W-1];
  assign wr_frm_s = bus_wr && (bus_addr == SHARED_ADDR) &&  bus_wdata[DATA_W-1];

  // R2
  div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div_s |=> div_hi_o == $past(bus_wdata[DIV_HI_W-1:0]));

  // R3
  frame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frm_s |=> frame_o == {1'b1, $past(bus_wdata[DATA_W-2:0])});

  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div_s |=> $stable(div_hi_o));

  // R4
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_frm_s |=> $stable(frame_o));

  // R6
  frame_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s |=> (!rd_s || (bus_rdata == frame_o && bus_rdata[DATA_W-1])));

  // R7
  div_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_s |=> (!rd_s || bus_rdata == {{PAD_W{1'b0}}, div_hi_o}));

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_s |-> bus_rdata == '0);
endmodule

bind shreg_pair shreg_pair_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_HI_W(DIV_HI_W), .SHARED_ADDR(SHARED_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .div_hi_o(div_hi_o), .frame_o(frame_o)
);

// File: tb/shreg_pair_tb_top.sv
module shreg_pair_tb_top;
  localparam int SH = 32;   // shared address 0x20

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] div_hi_o;
  logic [7:0] frame_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int m_div  = 0;
  int m_frm  = 'h86;
  bit m_prev = 0;

  always #5 clk = ~clk;

  shreg_pair dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_hi_o(div_hi_o), .frame_o(frame_o)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare mid-phase, update model at rising edge
  task automatic cyc(input int addr, input bit wr, input bit rd, input int wd, input string tag);
    bit hit;
    int exp_rd;
    @(negedge clk);
    bus_addr = addr[5:0]; bus_wr = wr; bus_rd = rd; bus_wdata = wd[7:0];
    #1;
    hit = (addr == SH);
    if (rd && hit) exp_rd = m_prev ? m_frm : m_div;
    else           exp_rd = 0;
    check((rd && hit) ? (m_prev ? "R6" : "R5") : "R9", bus_rdata, exp_rd, "rdata");
    check(tag, div_hi_o, m_div, "div_hi");
    check(tag, frame_o, m_frm, "frame");
    @(posedge clk);
    if (wr && hit) begin
      if (wd[7]) m_frm = wd & 'hFF;
      else       m_div = wd & 'hF;
    end
    m_prev = rd && hit;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, tag);
  endtask

  initial begin
    int lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", div_hi_o, 0, "reset div_hi");
    check("R1", frame_o, 'h86, "reset frame");
    rst_n = 1'b1;

    // R1: first read after reset gives divisor-high, then frame
    cyc(SH, 0, 1, 0, "R1");
    cyc(SH, 0, 1, 0, "R1");
    idle("R1");

    // R2: divisor-high write of 0x02
    cyc(SH, 1, 0, 'h02, "R2");
    idle("R2");
    @(negedge clk);
    check("R2", div_hi_o, 2, "div after 0x02");
    check("R2", frame_o, 'h86, "frame untouched");
    cyc(SH, 0, 1, 0, "R2");
    idle("R2");

    // R3: frame write 0x8C
    cyc(SH, 1, 0, 'h8C, "R3");
    idle("R3");
    @(negedge clk);
    check("R3", frame_o, 'h8C, "frame after 0x8C");
    check("R3", div_hi_o, 2, "div untouched");
    cyc(SH, 0, 1, 0, "R3");
    cyc(SH, 0, 1, 0, "R3");
    idle("R3");

    // R10: upper bits ignored for divisor-high
    cyc(SH, 1, 0, 'h7F, "R10");
    idle("R10");
    @(negedge clk);
    check("R10", div_hi_o, 'hF, "div after 0x7F");

    // R4: writes elsewhere are ignored
    cyc(SH + 1, 1, 0, 'h05, "R4");
    cyc(0, 1, 0, 'hC1, "R4");
    idle("R4");
    @(negedge clk);
    check("R4", div_hi_o, 'hF, "div after foreign write");
    check("R4", frame_o, 'h8C, "frame after foreign write");

    // R7: broken sequences
    cyc(SH, 0, 1, 0, "R7"); idle("R7"); cyc(SH, 0, 1, 0, "R7");
    cyc(SH, 1, 0, 'h03, "R7"); cyc(SH, 0, 1, 0, "R7");
    cyc(SH + 2, 0, 1, 0, "R7"); cyc(SH, 0, 1, 0, "R7");
    cyc(SH, 0, 1, 0, "R7");
    idle("R7");

    // R8: three back-to-back reads
    @(negedge clk);
    bus_addr = SH; bus_rd = 1; #1;
    check("R8", bus_rdata, 3, "read 1");
    @(negedge clk); #1;
    check("R8", bus_rdata, 'h8C, "read 2");
    @(negedge clk); #1;
    check("R8", bus_rdata, 'h8C, "read 3");
    @(posedge clk);
    m_prev = 1;
    idle("R8");

    // R9: idle read data
    @(negedge clk);
    check("R9", bus_rdata, 0, "idle rdata");

    // Mixed traffic against the model
    lfsr = 'hACE1;
    for (int i = 0; i < 400; i++) begin
      int a;
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
      a = (lfsr[3:2] == 2'b11) ? (lfsr[9:4] == SH ? 1 : lfsr[9:4]) : SH;
      cyc(a, lfsr[0], lfsr[1] | lfsr[4], lfsr[15:8], "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule